// File: doc/BRIEF.md
# FP condition predicate evaluator

This block decides a floating-point conditional instruction. It takes a 6-bit condition predicate and the four condition flags of the floating-point status word: negative, zero, infinity and not-a-number. It returns whether the condition holds and flags a predicate outside the legal range. It also produces the updated status word. The exception byte of that word is cleared first, and the branch-on-unordered exception is raised when an IEEE-unaware test meets an unordered operand.

For branch-type instructions the same evaluation also yields the program-counter advance. Three branch kinds are handled: a short branch with a 16-bit displacement, a long branch with a 32-bit displacement, and a decrement-and-branch loop with its 16-bit counter. An exception that is both raised and enabled becomes a trap that suppresses the branch. The decision logic is combinational. All results are captured in one output register stage, so they appear one cycle after the request.

Top module: `fp_cond_eval`

## Requirements
- R1: After reset, out_valid, result, illegal, trap, advance, stat_out and count_out are all zero.
- R2: Outputs update on the clock edge that samples in_valid high, with out_valid high for exactly that one following cycle. When in_valid is low, out_valid goes low and the other outputs hold their values.
- R3: A predicate with bit 5 set is illegal. It gives illegal=1, result=0, trap=0, stat_out equal to stat_in and count_out equal to count_in. The advance is the not-taken length: 4 for kinds 0 and 1, and 6 for kinds 2 and 3.
- R4: The flags sit at stat_in[27]=N, [26]=Z, [25]=I and [24]=NaN. Predicate bits [2:0] pick a base test: 0 false; 1 Z; 2 none of NaN, Z, N; 3 Z, or neither NaN nor N; 4 N with neither NaN nor Z; 5 Z, or N without NaN; 6 neither NaN nor Z; 7 not NaN. The I flag is never tested.
- R5: With predicate bit 3 set, the base test index is the bitwise inverse of bits [2:0], and the result is inverted.
- R6: For a legal predicate, stat_out[15:8] is cleared, and bit 15 (unordered exception) is then set when predicate bit 4 and NaN are both set. All other bits pass through unchanged.
- R7: The trap output is set when stat_out[15:8] & exc_en is nonzero. A trap suppresses the branch and the counter update, and the advance becomes the not-taken length.
- R8: The kind input selects 0 = condition test only (advance 4), 1 = short branch, 2 = long branch, 3 = decrement-and-branch. For kinds 0, 1 and 2, count_out equals count_in.
- R9: A taken short branch advances by sign-extended disp_a + 2, and a not-taken one by 4. A taken long branch advances by {disp_a, disp_b} + 2, and a not-taken one by 6.
- R10: Decrement-and-branch with a true condition advances by 6 and leaves the counter unchanged.
- R11: Decrement-and-branch with a false condition and a nonzero counter outputs counter - 1 and advances by 4 + sign-extended disp_a.
- R12: Decrement-and-branch with a false condition and a zero counter outputs 16'hFFFF and advances by 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| pred | input | 6 | Condition predicate |
| kind | input | 2 | Instruction kind |
| stat_in | input | 32 | Status word before evaluation |
| exc_en | input | 8 | Exception enables, aligned with stat bits 15:8 |
| disp_a | input | 16 | First displacement word |
| disp_b | input | 16 | Second displacement word (long branch) |
| count_in | input | 16 | Loop counter (low half of data register) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 1 | Predicate outcome |
| illegal | output | 1 | Predicate out of range |
| trap | output | 1 | Enabled exception raised |
| advance | output | 32 | Program-counter advance in bytes |
| stat_out | output | 32 | Updated status word |
| count_out | output | 16 | Updated loop counter |

## Verification
The only state is the output register, so a wrong captured value shows at the ports on the cycle after the request and survives only until the next request. A fault in the test selection or in the inversion folding shows as a wrong result for one particular predicate and flag pattern. For that reason the vectors cover every base test and both polarities. A fault in the exception handling shows in stat_out bit 15 or in trap, and it spreads into advance and count_out at once, because a trap forces the not-taken path.

// File: rtl/fp_cond_eval.sv
module fp_cond_eval (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [5:0]  pred,
  input  logic [1:0]  kind,
  input  logic [31:0] stat_in,
  input  logic [7:0]  exc_en,
  input  logic [15:0] disp_a,
  input  logic [15:0] disp_b,
  input  logic [15:0] count_in,
  output logic        out_valid,
  output logic        result,
  output logic        illegal,
  output logic        trap,
  output logic [31:0] advance,
  output logic [31:0] stat_out,
  output logic [15:0] count_out
);
  localparam int FL_N   = 27;
  localparam int FL_Z   = 26;
  localparam int FL_NAN = 24;
  localparam int EXC_HI = 15;
  localparam int EXC_LO = 8;
  localparam logic [1:0] K_TEST = 2'd0, K_SHORT = 2'd1, K_LONG = 2'd2, K_LOOP = 2'd3;

  wire legal   = ~pred[5];
  wire negate  = pred[3];
  wire [2:0] sel = pred[2:0] ^ {3{negate}};
  wire fn = stat_in[FL_N];
  wire fz = stat_in[FL_Z];
  wire fq = stat_in[FL_NAN];

  logic base;
  always_comb begin
    case (sel)
      3'd0: base = 1'b0;
      3'd1: base = fz;
      3'd2: base = ~(fq | fz | fn);
      3'd3: base = fz | ~(fq | fn);
      3'd4: base = fn & ~fq & ~fz;
      3'd5: base = fz | (fn & ~fq);
      3'd6: base = ~(fq | fz);
      default: base = ~fq;
    endcase
  end

  wire cond = legal & (base ^ negate);
  wire bsun = legal & pred[4] & fq;
  wire [31:0] stat_n = legal ? {stat_in[31:EXC_HI+1], bsun, 7'b0, stat_in[EXC_LO-1:0]} : stat_in;
  wire trap_n = legal & |(stat_n[EXC_HI:EXC_LO] & exc_en);
  wire go = cond & ~trap_n;
  wire [31:0] sdisp = {{16{disp_a[15]}}, disp_a};
  wire [31:0] ldisp = {disp_a, disp_b};

  logic [31:0] adv_n;
  logic [15:0] cnt_n;
  always_comb begin
    cnt_n = count_in;
    case (kind)
      K_TEST:  adv_n = 32'd4;
      K_SHORT: adv_n = go ? sdisp + 32'd2 : 32'd4;
      K_LONG:  adv_n = go ? ldisp + 32'd2 : 32'd6;
      default: begin
        adv_n = 32'd6;
        if (legal && !trap_n && !cond) begin
          cnt_n = count_in - 16'd1;
          if (count_in != 16'd0) adv_n = sdisp + 32'd4;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 1'b0;
      illegal   <= 1'b0;
      trap      <= 1'b0;
      advance   <= '0;
      stat_out  <= '0;
      count_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= cond;
        illegal   <= ~legal;
        trap      <= trap_n;
        advance   <= adv_n;
        stat_out  <= stat_n;
        count_out <= cnt_n;
      end
    end
  end
endmodule

// File: rtl/fp_cond_eval_chk.sv
module fp_cond_eval_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [5:0]  pred,
  input logic [1:0]  kind,
  input logic [31:0] stat_in,
  input logic [7:0]  exc_en,
  input logic [15:0] count_in,
  input logic        out_valid,
  input logic        result,
  input logic        illegal,
  input logic        trap,
  input logic [31:0] advance,
  input logic [31:0] stat_out,
  input logic [15:0] count_out
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(advance));
  p_illegal_inert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pred[5] |=> illegal && !result && !trap && stat_out == $past(stat_in));
  p_unaware_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pred[5:4] == 2'b01 && stat_in[24] |=> stat_out[15]);
  p_aware_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pred[5:4] == 2'b00 |=> stat_out[15:8] == 8'h00);
  p_trap_holds_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pred[5:4] == 2'b01 && stat_in[24] && exc_en[7] && kind == 2'd3
    |=> trap && count_out == $past(count_in) && advance == 32'd6);
  p_count_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && kind != 2'd3 |=> count_out == $past(count_in));
  p_expire_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && kind == 2'd3 && count_in == 16'd0
    |=> (count_out == 16'hFFFF && advance == 32'd6) || count_out == 16'd0);
endmodule

bind fp_cond_eval fp_cond_eval_chk u_chk (.*);

// File: tb/fp_cond_eval_bench.sv
`timescale 1ns/1ps
module fp_cond_eval_bench;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [5:0] pred = '0;
  logic [1:0] kind = '0;
  logic [31:0] stat_in = '0;
  logic [7:0] exc_en = '0;
  logic [15:0] disp_a = '0, disp_b = '0, count_in = '0;
  logic out_valid, result, illegal, trap;
  logic [31:0] advance, stat_out;
  logic [15:0] count_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp_cond_eval u_fp_cond_eval (.*);

  typedef struct packed {
    logic [5:0] pr; logic [1:0] kd; logic [3:0] cc;
    logic [15:0] da; logic [15:0] db; logic [15:0] cn; logic [7:0] en;
    logic res; logic ill; logic trp; logic bs;
    logic [31:0] adv; logic [15:0] cno; logic [7:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{6'h01, 2'd0, 4'b0100, 16'h0000, 16'h0000, 16'h1234, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 32'd4,          16'h1234, 8'd4},  // R4 equal
    '{6'h02, 2'd1, 4'b0000, 16'hFFF0, 16'h0000, 16'h1234, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFF2,   16'h1234, 8'd9},  // R9 short back
    '{6'h04, 2'd1, 4'b1000, 16'h0100, 16'h0000, 16'h1234, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000102,   16'h1234, 8'd4},  // R4 less
    '{6'h04, 2'd1, 4'b1001, 16'h0100, 16'h0000, 16'h1234, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 32'd4,          16'h1234, 8'd4},  // R4 less, NaN
    '{6'h14, 2'd1, 4'b1001, 16'h0100, 16'h0000, 16'h1234, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 32'd4,          16'h1234, 8'd6},  // R6 unaware NaN
    '{6'h14, 2'd2, 4'b1001, 16'h0100, 16'h0000, 16'h1234, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1, 32'd6,          16'h1234, 8'd7},  // R7 trap long
    '{6'h0F, 2'd2, 4'b0000, 16'h0001, 16'h0000, 16'h1234, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00010002,   16'h1234, 8'd5},  // R5 not-false
    '{6'h0E, 2'd2, 4'b0100, 16'h0001, 16'h0000, 16'h1234, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 32'd6,          16'h1234, 8'd5},  // R5 not-equal
    '{6'h03, 2'd3, 4'b0100, 16'hFFFC, 16'h0000, 16'h0005, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 32'd6,          16'h0005, 8'd10}, // R10
    '{6'h00, 2'd3, 4'b0000, 16'hFFFC, 16'h0000, 16'h0005, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0,          16'h0004, 8'd11}, // R11
    '{6'h00, 2'd3, 4'b0000, 16'hFFFC, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 32'd6,          16'hFFFF, 8'd12}, // R12
    '{6'h21, 2'd3, 4'b0000, 16'hFFFC, 16'h0000, 16'h0007, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 32'd6,          16'h0007, 8'd3},  // R3
    '{6'h1D, 2'd0, 4'b0001, 16'h0000, 16'h0000, 16'h1234, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 32'd4,          16'h1234, 8'd5},  // R5 not-greater
    '{6'h07, 2'd0, 4'b0001, 16'h0000, 16'h0000, 16'h1234, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 32'd4,          16'h1234, 8'd4},  // R4 ordered
    '{6'h06, 2'd0, 4'b0000, 16'h0000, 16'h0000, 16'h1234, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 32'd4,          16'h1234, 8'd4},  // R4 gl
    '{6'h05, 2'd0, 4'b1000, 16'h0000, 16'h0000, 16'h1234, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 32'd4,          16'h1234, 8'd4},  // R4 le
    '{6'h05, 2'd0, 4'b1001, 16'h0000, 16'h0000, 16'h1234, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 32'd4,          16'h1234, 8'd4},  // R4 le NaN
    '{6'h03, 2'd0, 4'b1000, 16'h0000, 16'h0000, 16'h1234, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 32'd4,          16'h1234, 8'd4},  // R4 ge neg
    '{6'h3F, 2'd1, 4'b0001, 16'h0100, 16'h0000, 16'h1234, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 32'd4,          16'h1234, 8'd3},  // R3 high
    '{6'h1F, 2'd3, 4'b0001, 16'h0010, 16'h0000, 16'h0003, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1, 32'd6,          16'h0003, 8'd7},  // R7 loop trap
    '{6'h02, 2'd2, 4'b0010, 16'hFFFF, 16'hFFF8, 16'h1234, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFA,   16'h1234, 8'd9},  // R9 long back
    '{6'h10, 2'd3, 4'b0001, 16'h0008, 16'h0000, 16'h0002, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 32'd12,         16'h0001, 8'd11}  // R11 with R6
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_stat(input logic [3:0] cc);
    return {4'h3, cc, 8'h5A, 8'h7F, 8'hC3};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0 && result == 1'b0 && illegal == 1'b0 && trap == 1'b0, 1, "reset flags",
        {28'd0, out_valid, result, illegal, trap}, 32'd0);
    chk(advance == 32'd0 && count_out == 16'd0, 1, "reset advance/count", advance, 32'd0);
    chk(stat_out == 32'd0, 1, "reset status", stat_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [31:0] st, exp_st;
      st = mk_stat(VEC[i].cc);
      exp_st = VEC[i].ill ? st : {4'h3, VEC[i].cc, 8'h5A, VEC[i].bs, 7'b0, 8'hC3};
      pred = VEC[i].pr; kind = VEC[i].kd; stat_in = st; exc_en = VEC[i].en;
      disp_a = VEC[i].da; disp_b = VEC[i].db; count_in = VEC[i].cn; in_valid = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b1, 2, "valid", {31'd0, out_valid}, 32'd1);
      chk(result == VEC[i].res, int'(VEC[i].req), "result", {31'd0, result}, {31'd0, VEC[i].res});
      chk(illegal == VEC[i].ill, 3, "illegal", {31'd0, illegal}, {31'd0, VEC[i].ill});
      chk(trap == VEC[i].trp, 7, "trap", {31'd0, trap}, {31'd0, VEC[i].trp});
      chk(advance == VEC[i].adv, int'(VEC[i].req), "advance", advance, VEC[i].adv);
      chk(count_out == VEC[i].cno, int'(VEC[i].req), "count", {16'd0, count_out}, {16'd0, VEC[i].cno});
      chk(stat_out == exp_st, 6, "status", stat_out, exp_st);
    end
    // R2 idle cycle: strobe drops, outputs hold the last result
    in_valid = 1'b0; pred = 6'h0F; kind = 2'd1; stat_in = 32'h0;
    @(negedge clk);
    chk(out_valid == 1'b0, 2, "idle valid", {31'd0, out_valid}, 32'd0);
    chk(advance == 32'd12 && count_out == 16'h0001, 2, "idle hold", advance, 32'd12);
    // R8 test kind ignores displacement, counter passes
    pred = 6'h0F; kind = 2'd0; stat_in = mk_stat(4'b0000); disp_a = 16'h7777;
    count_in = 16'h0000; exc_en = 8'h00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(advance == 32'd4 && count_out == 16'h0000, 8, "test kind", advance, 32'd4);
    // R10 loop with true condition at zero counter: no wrap
    pred = 6'h0F; kind = 2'd3; count_in = 16'h0000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(count_out == 16'h0000 && advance == 32'd6, 10, "loop true at zero", {16'd0, count_out}, 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule